// File: doc/BRIEF.md
# External Bus Zone Access Sequencer

The sequencer turns single read or write requests into strobe sequences on an external parallel memory bus. The bus address space is divided into chip-select zones. Every access goes through three phases: lead, active and trail. Each zone sets the length of each phase in its own configuration, with separate values for reads and for writes. A per-zone flag doubles every phase setting of that zone.

A bank zone is chosen by configuration. Whenever two consecutive accesses involve that zone, the sequencer inserts a programmable number of idle cycles with every chip-select released. This applies when the earlier access used the bank zone, when the later one does, or when both do. The next access is held for the full idle count whatever the earlier access's timing was, including the case where the idle count is longer than the earlier access itself.

Requests arrive on a valid/ready port and are served one at a time. Read data is returned with a single-cycle valid pulse.

Top module: `ezs_zone_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, all chip-selects, the read strobe and the write strobe are high, `req_ready` is high and `rd_valid` is low.
- R2: A request is taken in a cycle where `req_valid` and `req_ready` are both high. From the next cycle, `req_ready` stays low until the last trail cycle of that access has ended, including any bank idle cycles. Only one access is ever in progress.
- R3: The lead phase lasts L cycles, or 2L cycles when the zone's double flag is set. L is the lead setting for the access direction. A zero-length lead is skipped. During lead the zone's chip-select is low and both strobes are high. Per-zone fields are packed with zone z at bits `[z*W +: W]`, where W is the field width, and the double flag of zone z is bit z.
- R4: The active phase lasts A+1 cycles, or 2A+1 cycles when doubled. During it the chip-select stays low, the strobe for the access direction is low (`bus_rd_n` for a read, `bus_we_n` for a write) and the other strobe stays high. `bus_addr` carries the request address, and `bus_dout` carries the write data on a write.
- R5: The trail phase lasts T cycles, or 2T cycles when doubled. During it the chip-select is low and both strobes are high. A zero-length trail is skipped.
- R6: At most one chip-select is low at any time. The low bit is the one whose index equals the request's zone number.
- R7: When the previous access or the new one targets the bank zone, exactly B cycles with every chip-select high pass between acceptance and the new access's first chip-select cycle, where B is the bank cycle setting. This holds for any B, including a B that is not smaller than the earlier access's total length.
- R8: No bank idle cycles are inserted when neither access of a consecutive pair targets the bank zone, or for the first access after reset. The chip-select goes low in the cycle right after acceptance.
- R9: For a read, `bus_din` is sampled in the last active cycle. It is returned on `rd_data` with `rd_valid` high for exactly the one cycle that follows the active phase. Writes produce no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_zone | input | ZONE_W | Target zone number |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle read data valid pulse |
| rd_data | output | DATA_W | Returned read data |
| cfg_rd_lead | input | NZONES*LEAD_W | Per-zone read lead setting |
| cfg_rd_act | input | NZONES*ACT_W | Per-zone read active setting |
| cfg_rd_trail | input | NZONES*TRAIL_W | Per-zone read trail setting |
| cfg_wr_lead | input | NZONES*LEAD_W | Per-zone write lead setting |
| cfg_wr_act | input | NZONES*ACT_W | Per-zone write active setting |
| cfg_wr_trail | input | NZONES*TRAIL_W | Per-zone write trail setting |
| cfg_dbl | input | NZONES | Per-zone phase doubling flag |
| cfg_bank_zone | input | ZONE_W | Zone that triggers bank idle cycles |
| cfg_bank_cycles | input | BCYC_W | Number of bank idle cycles |
| bus_cs_n | output | NZONES | Chip-selects, active low, one per zone |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_addr | output | ADDR_W | Bus address |
| bus_dout | output | DATA_W | Bus write data |
| bus_din | input | DATA_W | Bus read data |

## Verification
The hardest case to reach is a bank idle count that is as long as or longer than the whole previous access. This needs a zone with every phase setting at zero and no doubling, followed at once by an entry into the bank zone with the largest idle count. The stimulus also has to cover each of the three ways a pair can involve the bank zone: leaving it, entering it, and staying in it. Directed sequences build exactly these pairs, including the minimal-zone case and a zero idle count. Seeded random traffic then re-draws every zone's timing, the bank zone and the idle count every twenty accesses, so that the gap is measured against many mixes of prior zone length and bank setting.

// File: rtl/ezs_pkg.sv
package ezs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BANK  = 3'd1,
        ST_LEAD  = 3'd2,
        ST_ACT   = 3'd3,
        ST_TRAIL = 3'd4
    } ezs_state_e;

    function automatic int ezs_max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/ezs_phase_calc.sv
module ezs_phase_calc #(
    parameter int NZONES  = 4,
    parameter int LEAD_W  = 2,
    parameter int ACT_W   = 3,
    parameter int TRAIL_W = 2,
    parameter int LEN_W   = 4,
    localparam int ZONE_W = $clog2(NZONES)
) (
    input  logic [ZONE_W-1:0]          zone,
    input  logic                       wr,
    input  logic [NZONES*LEAD_W-1:0]   cfg_rd_lead,
    input  logic [NZONES*ACT_W-1:0]    cfg_rd_act,
    input  logic [NZONES*TRAIL_W-1:0]  cfg_rd_trail,
    input  logic [NZONES*LEAD_W-1:0]   cfg_wr_lead,
    input  logic [NZONES*ACT_W-1:0]    cfg_wr_act,
    input  logic [NZONES*TRAIL_W-1:0]  cfg_wr_trail,
    input  logic [NZONES-1:0]          cfg_dbl,
    output logic [LEN_W-1:0]           lead_len,
    output logic [LEN_W-1:0]           act_len,
    output logic [LEN_W-1:0]           trail_len
);

    logic [LEN_W-1:0] lead_z  [NZONES];
    logic [LEN_W-1:0] act_z   [NZONES];
    logic [LEN_W-1:0] trail_z [NZONES];

    for (genvar z = 0; z < NZONES; z++) begin : g_zone
        logic [LEAD_W-1:0]  lset;
        logic [ACT_W-1:0]   aset;
        logic [TRAIL_W-1:0] tset;

        assign lset = wr ? cfg_wr_lead[z*LEAD_W +: LEAD_W]    : cfg_rd_lead[z*LEAD_W +: LEAD_W];
        assign aset = wr ? cfg_wr_act[z*ACT_W +: ACT_W]       : cfg_rd_act[z*ACT_W +: ACT_W];
        assign tset = wr ? cfg_wr_trail[z*TRAIL_W +: TRAIL_W] : cfg_rd_trail[z*TRAIL_W +: TRAIL_W];

        assign lead_z[z]  = cfg_dbl[z] ? (LEN_W'(lset) << 1) : LEN_W'(lset);
        assign act_z[z]   = (cfg_dbl[z] ? (LEN_W'(aset) << 1) : LEN_W'(aset)) + LEN_W'(1);
        assign trail_z[z] = cfg_dbl[z] ? (LEN_W'(tset) << 1) : LEN_W'(tset);
    end

    assign lead_len  = lead_z[zone];
    assign act_len   = act_z[zone];
    assign trail_len = trail_z[zone];

endmodule

// File: rtl/ezs_bank_gate.sv
module ezs_bank_gate #(
    parameter int ZONE_W = 2,
    parameter int BCYC_W = 3
) (
    input  logic              have_prev,
    input  logic [ZONE_W-1:0] prev_zone,
    input  logic [ZONE_W-1:0] new_zone,
    input  logic [ZONE_W-1:0] bank_zone,
    input  logic [BCYC_W-1:0] bank_cycles,
    output logic [BCYC_W-1:0] gap_len
);

    logic involved;

    // Entering, leaving or staying in the bank zone all count.
    assign involved = have_prev && ((prev_zone == bank_zone) || (new_zone == bank_zone));
    assign gap_len  = involved ? bank_cycles : '0;

endmodule

// File: rtl/ezs_cs_decode.sv
module ezs_cs_decode #(
    parameter int NZONES = 4,
    parameter int ZONE_W = 2
) (
    input  logic [ZONE_W-1:0] zone,
    input  logic              active,
    output logic [NZONES-1:0] cs_n
);

    for (genvar z = 0; z < NZONES; z++) begin : g_cs
        assign cs_n[z] = !(active && (zone == ZONE_W'(z)));
    end

endmodule

// File: rtl/ezs_zone_seq.sv
module ezs_zone_seq
    import ezs_pkg::*;
#(
    parameter int NZONES  = 4,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int LEAD_W  = 2,
    parameter int ACT_W   = 3,
    parameter int TRAIL_W = 2,
    parameter int BCYC_W  = 3,
    localparam int ZONE_W = $clog2(NZONES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [ZONE_W-1:0]          req_zone,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [DATA_W-1:0]          req_wdata,
    output logic                       rd_valid,
    output logic [DATA_W-1:0]          rd_data,
    input  logic [NZONES*LEAD_W-1:0]   cfg_rd_lead,
    input  logic [NZONES*ACT_W-1:0]    cfg_rd_act,
    input  logic [NZONES*TRAIL_W-1:0]  cfg_rd_trail,
    input  logic [NZONES*LEAD_W-1:0]   cfg_wr_lead,
    input  logic [NZONES*ACT_W-1:0]    cfg_wr_act,
    input  logic [NZONES*TRAIL_W-1:0]  cfg_wr_trail,
    input  logic [NZONES-1:0]          cfg_dbl,
    input  logic [ZONE_W-1:0]          cfg_bank_zone,
    input  logic [BCYC_W-1:0]          cfg_bank_cycles,
    output logic [NZONES-1:0]          bus_cs_n,
    output logic                       bus_rd_n,
    output logic                       bus_we_n,
    output logic [ADDR_W-1:0]          bus_addr,
    output logic [DATA_W-1:0]          bus_dout,
    input  logic [DATA_W-1:0]          bus_din
);

    // One bit of headroom covers doubling and the +1 of the active phase.
    localparam int LEN_W = ezs_max4(LEAD_W, ACT_W, TRAIL_W, BCYC_W) + 1;

    typedef struct packed {
        ezs_state_e         st;
        logic [LEN_W-1:0]   cnt;
        logic [ZONE_W-1:0]  zone;
        logic               wr;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic [LEN_W-1:0]   lead_len;
        logic [LEN_W-1:0]   act_len;
        logic [LEN_W-1:0]   trail_len;
        logic               have_prev;
        logic [ZONE_W-1:0]  prev_zone;
        logic               rd_vld;
        logic [DATA_W-1:0]  rd_data;
    } seq_s;

    seq_s seq_d, seq_q;

    logic [LEN_W-1:0]  new_lead, new_act, new_trail;
    logic [BCYC_W-1:0] gap_len;
    logic              accept;
    logic              in_access;

    ezs_phase_calc #(
        .NZONES (NZONES),
        .LEAD_W (LEAD_W),
        .ACT_W  (ACT_W),
        .TRAIL_W(TRAIL_W),
        .LEN_W  (LEN_W)
    ) u_phase (
        .zone        (req_zone),
        .wr          (req_write),
        .cfg_rd_lead (cfg_rd_lead),
        .cfg_rd_act  (cfg_rd_act),
        .cfg_rd_trail(cfg_rd_trail),
        .cfg_wr_lead (cfg_wr_lead),
        .cfg_wr_act  (cfg_wr_act),
        .cfg_wr_trail(cfg_wr_trail),
        .cfg_dbl     (cfg_dbl),
        .lead_len    (new_lead),
        .act_len     (new_act),
        .trail_len   (new_trail)
    );

    ezs_bank_gate #(
        .ZONE_W(ZONE_W),
        .BCYC_W(BCYC_W)
    ) u_bank (
        .have_prev  (seq_q.have_prev),
        .prev_zone  (seq_q.prev_zone),
        .new_zone   (req_zone),
        .bank_zone  (cfg_bank_zone),
        .bank_cycles(cfg_bank_cycles),
        .gap_len    (gap_len)
    );

    assign accept = req_valid && (seq_q.st == ST_IDLE);

    always_comb begin
        seq_d        = seq_q;
        seq_d.rd_vld = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (accept) begin
                    seq_d.zone      = req_zone;
                    seq_d.wr        = req_write;
                    seq_d.addr      = req_addr;
                    seq_d.wdata     = req_wdata;
                    seq_d.lead_len  = new_lead;
                    seq_d.act_len   = new_act;
                    seq_d.trail_len = new_trail;
                    seq_d.have_prev = 1'b1;
                    seq_d.prev_zone = req_zone;
                    if (gap_len != '0) begin
                        seq_d.st  = ST_BANK;
                        seq_d.cnt = LEN_W'(gap_len);
                    end else if (new_lead != '0) begin
                        seq_d.st  = ST_LEAD;
                        seq_d.cnt = new_lead;
                    end else begin
                        seq_d.st  = ST_ACT;
                        seq_d.cnt = new_act;
                    end
                end
            end
            ST_BANK: begin
                if (seq_q.cnt == LEN_W'(1)) begin
                    if (seq_q.lead_len != '0) begin
                        seq_d.st  = ST_LEAD;
                        seq_d.cnt = seq_q.lead_len;
                    end else begin
                        seq_d.st  = ST_ACT;
                        seq_d.cnt = seq_q.act_len;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt - LEN_W'(1);
                end
            end
            ST_LEAD: begin
                if (seq_q.cnt == LEN_W'(1)) begin
                    seq_d.st  = ST_ACT;
                    seq_d.cnt = seq_q.act_len;
                end else begin
                    seq_d.cnt = seq_q.cnt - LEN_W'(1);
                end
            end
            ST_ACT: begin
                if (seq_q.cnt == LEN_W'(1)) begin
                    if (!seq_q.wr) begin
                        seq_d.rd_vld  = 1'b1;
                        seq_d.rd_data = bus_din;
                    end
                    if (seq_q.trail_len != '0) begin
                        seq_d.st  = ST_TRAIL;
                        seq_d.cnt = seq_q.trail_len;
                    end else begin
                        seq_d.st  = ST_IDLE;
                        seq_d.cnt = '0;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt - LEN_W'(1);
                end
            end
            ST_TRAIL: begin
                if (seq_q.cnt == LEN_W'(1)) begin
                    seq_d.st  = ST_IDLE;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt - LEN_W'(1);
                end
            end
            default: begin
                seq_d.st  = ST_IDLE;
                seq_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign in_access = (seq_q.st == ST_LEAD) || (seq_q.st == ST_ACT) || (seq_q.st == ST_TRAIL);

    ezs_cs_decode #(
        .NZONES(NZONES),
        .ZONE_W(ZONE_W)
    ) u_cs (
        .zone  (seq_q.zone),
        .active(in_access),
        .cs_n  (bus_cs_n)
    );

    assign req_ready = (seq_q.st == ST_IDLE);
    assign bus_rd_n  = !((seq_q.st == ST_ACT) && !seq_q.wr);
    assign bus_we_n  = !((seq_q.st == ST_ACT) && seq_q.wr);
    assign bus_addr  = seq_q.addr;
    assign bus_dout  = seq_q.wdata;
    assign rd_valid  = seq_q.rd_vld;
    assign rd_data   = seq_q.rd_data;

endmodule

// File: rtl/ezs_checks.sv
module ezs_checks #(
    parameter int NZONES = 4,
    parameter int ZONE_W = 2,
    parameter int BCYC_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NZONES-1:0] bus_cs_n,
    input logic              bus_rd_n,
    input logic              bus_we_n,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ZONE_W-1:0] cfg_bank_zone,
    input logic [BCYC_W-1:0] cfg_bank_cycles
);

    localparam int IDW = BCYC_W + 2;

    logic              any_cs;
    logic              was_any_q;
    logic              have_prev_q;
    logic [ZONE_W-1:0] cur_zone;
    logic [ZONE_W-1:0] prev_zone_q;
    logic [IDW-1:0]    idle_q;
    logic              cs_start;

    assign any_cs   = ~&bus_cs_n;
    assign cs_start = any_cs && !was_any_q;

    always_comb begin
        cur_zone = '0;
        for (int i = 0; i < NZONES; i++) begin
            if (!bus_cs_n[i]) cur_zone = ZONE_W'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            was_any_q   <= 1'b0;
            have_prev_q <= 1'b0;
            prev_zone_q <= '0;
            idle_q      <= '0;
        end else begin
            was_any_q <= any_cs;
            if (any_cs) begin
                idle_q      <= '0;
                have_prev_q <= 1'b1;
                prev_zone_q <= cur_zone;
            end else if (idle_q != '1) begin
                idle_q <= idle_q + IDW'(1);
            end
        end
    end

    AST_ONE_ZONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bus_cs_n)); // R6

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> bus_we_n); // R4

    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || !bus_we_n) |-> any_cs); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !any_cs); // R2

    AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R9

    AST_RDV_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(!bus_rd_n) && bus_rd_n)); // R9

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_start && have_prev_q && ((prev_zone_q == cfg_bank_zone) || (cur_zone == cfg_bank_zone)))
        |-> (idle_q >= (IDW'(cfg_bank_cycles) + IDW'(1)))); // R7

endmodule

bind ezs_zone_seq ezs_checks #(
    .NZONES(NZONES),
    .ZONE_W(ZONE_W),
    .BCYC_W(BCYC_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_cs_n       (bus_cs_n),
    .bus_rd_n       (bus_rd_n),
    .bus_we_n       (bus_we_n),
    .req_ready      (req_ready),
    .rd_valid       (rd_valid),
    .cfg_bank_zone  (cfg_bank_zone),
    .cfg_bank_cycles(cfg_bank_cycles)
);

// File: tb/ezs_zone_seq_tb.sv
module ezs_zone_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NZONES  = 4;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 16;
    localparam int LEAD_W  = 2;
    localparam int ACT_W   = 3;
    localparam int TRAIL_W = 2;
    localparam int BCYC_W  = 3;
    localparam int ZONE_W  = $clog2(NZONES);
    localparam int WD_CYCLES = 150000;
    localparam logic [DATA_W-1:0] DIN_KEY = 16'h5A3C;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      req_valid = 1'b0;
    logic                      req_ready;
    logic [ZONE_W-1:0]         req_zone = '0;
    logic                      req_write = 1'b0;
    logic [ADDR_W-1:0]         req_addr = '0;
    logic [DATA_W-1:0]         req_wdata = '0;
    logic                      rd_valid;
    logic [DATA_W-1:0]         rd_data;
    logic [NZONES*LEAD_W-1:0]  p_rl, p_wl;
    logic [NZONES*ACT_W-1:0]   p_ra, p_wa;
    logic [NZONES*TRAIL_W-1:0] p_rt, p_wt;
    logic [NZONES-1:0]         c_dbl = '0;
    logic [ZONE_W-1:0]         c_bank = '0;
    logic [BCYC_W-1:0]         c_bcyc = '0;
    logic [NZONES-1:0]         bus_cs_n;
    logic                      bus_rd_n, bus_we_n;
    logic [ADDR_W-1:0]         bus_addr;
    logic [DATA_W-1:0]         bus_dout;
    logic [DATA_W-1:0]         bus_din;

    int c_rl [NZONES];
    int c_wl [NZONES];
    int c_ra [NZONES];
    int c_wa [NZONES];
    int c_rt [NZONES];
    int c_wt [NZONES];

    int n_chk = 0;
    int n_bad = 0;
    bit have_prev = 0;
    int prev_z = 0;
    int seed_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign bus_din = DATA_W'(bus_addr) ^ DIN_KEY;

    always_comb begin
        for (int z = 0; z < NZONES; z++) begin
            p_rl[z*LEAD_W +: LEAD_W]   = LEAD_W'(c_rl[z]);
            p_wl[z*LEAD_W +: LEAD_W]   = LEAD_W'(c_wl[z]);
            p_ra[z*ACT_W +: ACT_W]     = ACT_W'(c_ra[z]);
            p_wa[z*ACT_W +: ACT_W]     = ACT_W'(c_wa[z]);
            p_rt[z*TRAIL_W +: TRAIL_W] = TRAIL_W'(c_rt[z]);
            p_wt[z*TRAIL_W +: TRAIL_W] = TRAIL_W'(c_wt[z]);
        end
    end

    ezs_zone_seq #(
        .NZONES(NZONES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .LEAD_W(LEAD_W), .ACT_W(ACT_W), .TRAIL_W(TRAIL_W), .BCYC_W(BCYC_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_zone(req_zone),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .cfg_rd_lead(p_rl), .cfg_rd_act(p_ra), .cfg_rd_trail(p_rt),
        .cfg_wr_lead(p_wl), .cfg_wr_act(p_wa), .cfg_wr_trail(p_wt),
        .cfg_dbl(c_dbl), .cfg_bank_zone(c_bank), .cfg_bank_cycles(c_bcyc),
        .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_we_n(bus_we_n),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_din(bus_din)
    );

    function automatic int mult(int z);
        return c_dbl[z] ? 2 : 1;
    endfunction

    function automatic int exp_lead(int z, bit w);
        return (w ? c_wl[z] : c_rl[z]) * mult(z);
    endfunction

    function automatic int exp_act(int z, bit w);
        return (w ? c_wa[z] : c_ra[z]) * mult(z) + 1;
    endfunction

    function automatic int exp_trail(int z, bit w);
        return (w ? c_wt[z] : c_rt[z]) * mult(z);
    endfunction

    function automatic bit bank_involved(int z);
        return have_prev && ((prev_z == int'(c_bank)) || (z == int'(c_bank)));
    endfunction

    task automatic check_eq(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_all_zones(int l, int a, int t);
        for (int z = 0; z < NZONES; z++) begin
            c_rl[z] = l; c_wl[z] = l;
            c_ra[z] = a; c_wa[z] = a;
            c_rt[z] = t; c_wt[z] = t;
        end
    endtask

    task automatic randomize_cfg();
        for (int z = 0; z < NZONES; z++) begin
            c_rl[z] = $urandom_range(0, (1 << LEAD_W) - 1);
            c_wl[z] = $urandom_range(0, (1 << LEAD_W) - 1);
            c_ra[z] = $urandom_range(0, (1 << ACT_W) - 1);
            c_wa[z] = $urandom_range(0, (1 << ACT_W) - 1);
            c_rt[z] = $urandom_range(0, (1 << TRAIL_W) - 1);
            c_wt[z] = $urandom_range(0, (1 << TRAIL_W) - 1);
            c_dbl[z] = 1'($urandom_range(0, 1));
        end
        c_bank = ZONE_W'($urandom_range(0, NZONES - 1));
        c_bcyc = BCYC_W'($urandom_range(0, (1 << BCYC_W) - 1));
    endtask

    // Runs one access from an idle negedge; returns at the first idle negedge after it.
    task automatic do_access(int z, bit w, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        int gap = 0, ld = 0, ac = 0, tr = 0;
        int e_gap;
        bit cs_ok = 1, bus_ok = 1, busy_ok = 1;
        logic [NZONES-1:0] exp_cs;
        exp_cs = '1;
        exp_cs[z] = 1'b0;
        e_gap = bank_involved(z) ? int'(c_bcyc) : 0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_zone  = ZONE_W'(z);
        req_write = w;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (&bus_cs_n) begin
            if (req_ready) busy_ok = 0;
            gap++;
            @(negedge clk);
        end
        while (!(&bus_cs_n) && bus_rd_n && bus_we_n) begin
            if (bus_cs_n !== exp_cs) cs_ok = 0;
            if (req_ready) busy_ok = 0;
            ld++;
            @(negedge clk);
        end
        while (!bus_rd_n || !bus_we_n) begin
            if (bus_cs_n !== exp_cs) cs_ok = 0;
            if (req_ready) busy_ok = 0;
            if (w ? (bus_we_n !== 1'b0 || bus_rd_n !== 1'b1)
                  : (bus_rd_n !== 1'b0 || bus_we_n !== 1'b1)) bus_ok = 0;
            if (bus_addr !== a || (w && bus_dout !== d)) bus_ok = 0;
            ac++;
            @(negedge clk);
        end
        // First cycle after the active phase.
        if (w) begin
            check_eq("R9", "rd_valid after write", int'(rd_valid), 0);
        end else begin
            check_eq("R9", "rd_valid after read", int'(rd_valid), 1);
            check_eq("R9", "rd_data", int'(rd_data), int'(a ^ DIN_KEY));
        end
        while (!(&bus_cs_n)) begin
            if (bus_cs_n !== exp_cs) cs_ok = 0;
            if (req_ready) busy_ok = 0;
            tr++;
            @(negedge clk);
        end
        check_eq(bank_involved(z) ? "R7" : "R8", "bank idle cycles", gap, e_gap);
        check_eq("R3", "lead cycles", ld, exp_lead(z, w));
        check_eq("R4", "active cycles", ac, exp_act(z, w));
        check_eq("R5", "trail cycles", tr, exp_trail(z, w));
        check_eq("R6", "chip-select pattern ok", int'(cs_ok), 1);
        check_eq("R4", "strobe/address/data ok", int'(bus_ok), 1);
        check_eq("R2", "ready low while busy", int'(busy_ok), 1);
        check_eq("R2", "ready after access", int'(req_ready), 1);
        have_prev = 1;
        prev_z = z;
    endtask

    task automatic print_summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog: actual hung expected completion");
        print_summary();
        $finish;
    end

    initial begin
        seed_val = $urandom(7919);
        set_all_zones(1, 2, 1);
        c_bank = 2'd2;
        c_bcyc = 3'd5;
        repeat (4) @(negedge clk);
        // R1: outputs while reset is held
        check_eq("R1", "cs_n in reset", int'(bus_cs_n), (1 << NZONES) - 1);
        check_eq("R1", "rd_valid in reset", int'(rd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "cs_n after reset", int'(bus_cs_n), (1 << NZONES) - 1);
        check_eq("R1", "strobes after reset", int'({bus_rd_n, bus_we_n}), 3);
        check_eq("R1", "ready after reset", int'(req_ready), 1);
        check_eq("R1", "rd_valid after reset", int'(rd_valid), 0);

        // Zone 3 doubled, zone 1 minimal (total length 1).
        c_dbl[3] = 1'b1;
        c_rl[1] = 0; c_wl[1] = 0; c_ra[1] = 0; c_wa[1] = 0; c_rt[1] = 0; c_wt[1] = 0;
        c_wl[0] = 2; c_wa[0] = 5; c_wt[0] = 3;

        do_access(2, 0, 16'h1000, 16'h0);     // R8 first after reset
        do_access(2, 1, 16'h1002, 16'hBEEF);  // R7 staying in bank
        do_access(0, 0, 16'h0040, 16'h0);     // R7 leaving
        do_access(3, 1, 16'h3FFE, 16'h1234);  // R8 neither, doubled
        do_access(1, 0, 16'h2222, 16'h0);     // R8 neither, minimal
        c_bcyc = 3'd7;
        do_access(2, 1, 16'h2468, 16'hA5A5);  // R7 count exceeds prior length
        do_access(1, 1, 16'h1357, 16'h5A5A);  // R7 leaving into minimal zone
        do_access(0, 1, 16'h0F0F, 16'hC3C3);  // R8 separate write settings
        c_bcyc = 3'd0;
        do_access(2, 0, 16'h7777, 16'h0);     // R7 zero count gives no gap

        for (int i = 0; i < 300; i++) begin
            if (i % 20 == 0) randomize_cfg();
            do_access($urandom_range(0, NZONES - 1), 1'($urandom_range(0, 1)),
                      ADDR_W'($urandom), DATA_W'($urandom));
        end

        print_summary();
        $finish;
    end

endmodule